// File: doc/BRIEF.md
# DMA Status Mirror with Masked Edge Interrupt

This block lets a local microcontroller watch a four-channel DMA controller without taking over the system bus. It holds a small model of the controller's own status source: one request-pending flag per channel, which follows that channel's request line, and one terminal-count flag per channel, which is set by a one-cycle event pulse. The block shows both sets of flags to the microcontroller through a read-only mirror register. Reading the mirror has no side effect. The terminal-count flags clear only when the source itself is read through a separate bus I/O window address.

An 8-bit enable mask chooses which mirrored bits may raise the interrupt. A flag is latched whenever an enabled bit goes from low to high. That flag drives the active-high interrupt output until software clears it by writing a 1. Typical use is to enable only the terminal-count bits. The interrupt then means "transfer finished", and the microcontroller takes the bus and programs the next transfer. The request bits can instead be enabled as extra interrupt sources, or left masked and only watched.

Top module: `dma_status_mirror`

## Requirements
- R1: The status register at address 0 holds request-pending for channels 3..0 in bits 7..4, and terminal-count-reached for channels 3..0 in bits 3..0. A 1 means pending or reached.
- R2: The status register follows the live source state and is not a snapshot. A request bit equals the channel's request line as sampled at the previous clock edge. A terminal-count bit is 1 from the clock edge that samples its event pulse.
- R3: Reading address 0, with or without the read strobe, changes no bit of the status register.
- R4: A read strobe at address 3 (the I/O window) returns the same status byte. At that clock edge it clears bits 3..0 and leaves bits 7..4 as they were. If a channel's event pulse arrives in the same cycle, that channel's terminal-count bit ends up set.
- R5: The enable mask is an 8-bit read/write register at address 1, with bit n enabling status bit n. Writes to addresses 0 and 3 have no effect.
- R6: The interrupt flag is set one clock after any enabled status bit rises from 0 to 1. A rise of a masked bit or a fall of any bit leaves the flag unchanged.
- R7: Enabling a mask bit whose status bit is already 1 does not set the flag.
- R8: The flag stays set until a write to address 2 with data bit 0 equal to 1. A write with bit 0 equal to 0 does not clear it. A clear write in the same cycle as an enabled rise leaves the flag set.
- R9: The interrupt output is active high and equals the flag. Address 2 reads back the flag in bit 0 and zeros in bits 7..1.
- R10: A synchronous active-low reset clears the mask, the flag, the edge history and all source flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 interrupt, 3 I/O window |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe (has an effect only at address 3) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for the selected register |
| req_in | input | 4 | Per-channel request lines (level) |
| tc_evt | input | 4 | Per-channel terminal-count event pulses |
| irq | output | 1 | Latched interrupt, active high |

## Verification
A change on a request line reaches the status register one clock edge after it is driven. A terminal-count pulse does the same. The interrupt rises one edge later still, so it is due two edges after the stimulus. The window-read clear and the mask write take effect at the edge of the strobe, while read data is combinational and valid within the same cycle. The bench drives inputs just after a rising edge and lets two edges pass before it compares the status byte and the interrupt pin. It reads register contents a delta after changing the address, without an edge. The same-cycle cases are staged so that the rise is already visible when the clear write is applied: an event together with a window read, and an edge together with a clear write.

// File: rtl/dmam_pkg.sv
// Shared definitions for the DMA status mirror.
// Assumes a 2-bit register address space with four registers.
package dmam_pkg;
    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_IRQ  = 2'd2,
        ADDR_WIN  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/dmam_src_model.sv
// Model of the DMA controller's status source: per-channel request and
// terminal-count flags. Assumes tc_evt is a one-cycle pulse per event and
// win_rd is a one-cycle strobe for a read through the bus I/O window.
module dmam_src_model #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_in,
    input  logic [NCH-1:0] tc_evt,
    input  logic           win_rd,
    output logic [NCH-1:0] req_q,
    output logic [NCH-1:0] tc_q
);
    // Request flags sample the request lines every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_in;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic tc_bit;
        // Terminal-count flag: an event sets it, a window read clears it, and the event wins a tie.
        always_ff @(posedge clk) begin
            if (!rst_n)         tc_bit <= 1'b0;
            else if (tc_evt[c]) tc_bit <= 1'b1;
            else if (win_rd)    tc_bit <= 1'b0;
        end
        assign tc_q[c] = tc_bit;
    end

    p_req_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_q == $past(req_in)));
    p_tc_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_evt) |=> ((tc_q & $past(tc_evt)) == $past(tc_evt)));
    p_tc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_rd |=> ((tc_q & ~$past(tc_evt)) == '0));
    p_req_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && $stable(req_in)) |=> $stable(req_q));
endmodule

// File: rtl/dmam_regs.sv
// Register decode: mask storage, read mux, window-read strobe and the
// interrupt-clear strobe. Assumes at most one of wr/rd is acted on per address.
module dmam_regs
    import dmam_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [SW-1:0] wdata,
    input  logic [SW-1:0] status,
    input  logic          irq_flag,
    output logic [SW-1:0] rdata,
    output logic [SW-1:0] mask,
    output logic          win_rd,
    output logic          irq_clr
);
    reg_addr_e sel;
    logic      mask_wr;

    // Decode the address and the strobes.
    always_comb begin
        sel     = reg_addr_e'(addr);
        mask_wr = wr && (sel == ADDR_MASK);
        win_rd  = rd && (sel == ADDR_WIN);
        irq_clr = wr && (sel == ADDR_IRQ) && wdata[0];
    end

    // Enable mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= wdata;
    end

    // Read data mux.
    always_comb begin
        unique case (sel)
            ADDR_STAT: rdata = status;
            ADDR_MASK: rdata = mask;
            ADDR_IRQ:  rdata = {{(SW-1){1'b0}}, irq_flag};
            ADDR_WIN:  rdata = status;
            default:   rdata = '0;
        endcase
    end

    p_mask_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(wdata)));
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask));
endmodule

// File: rtl/dmam_edge_irq.sv
// Masked rising-edge detector and interrupt latch. Compares each status
// bit with its value one clock earlier, so a mask change alone never
// makes an edge. A clear loses to a simultaneous edge.
module dmam_edge_irq #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] status,
    input  logic [SW-1:0] mask,
    input  logic          irq_clr,
    output logic          rise_any,
    output logic          irq_flag
);
    logic [SW-1:0] prev_q;

    // Remember last cycle's status for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= status;
    end

    // An enabled bit that was low and is now high is an edge.
    assign rise_any = |(status & ~prev_q & mask);

    // Interrupt latch: an edge sets it, a clear drops it, and the edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_flag <= 1'b0;
        else if (rise_any) irq_flag <= 1'b1;
        else if (irq_clr)  irq_flag <= 1'b0;
    end

    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_any |=> irq_flag);
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag && !rise_any) |=> !irq_flag);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && irq_clr && !rise_any) |=> !irq_flag);
endmodule

// File: rtl/dma_status_mirror.sv
// Top: mirrors a four-channel DMA status source to a microcontroller and
// raises a masked, latched, rising-edge interrupt. The mirror has no
// storage of its own. It is the live source status.
module dma_status_mirror #(
    parameter  int NCH = 4,
    localparam int SW  = 2 * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     reg_addr,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [SW-1:0]  reg_wdata,
    output logic [SW-1:0]  reg_rdata,
    input  logic [NCH-1:0] req_in,
    input  logic [NCH-1:0] tc_evt,
    output logic           irq
);
    logic [NCH-1:0] req_q, tc_q;
    logic [SW-1:0]  status, mask;
    logic           win_rd, irq_clr, irq_flag, rise_any;

    dmam_src_model #(.NCH(NCH)) u_src (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .tc_evt(tc_evt),
        .win_rd(win_rd), .req_q(req_q), .tc_q(tc_q)
    );

    // Requests in the upper half, terminal counts in the lower half.
    assign status = {req_q, tc_q};

    dmam_regs #(.SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .status(status), .irq_flag(irq_flag),
        .rdata(reg_rdata), .mask(mask), .win_rd(win_rd), .irq_clr(irq_clr)
    );

    dmam_edge_irq #(.SW(SW)) u_irq (
        .clk(clk), .rst_n(rst_n), .status(status), .mask(mask),
        .irq_clr(irq_clr), .rise_any(rise_any), .irq_flag(irq_flag)
    );

    assign irq = irq_flag;

    p_stat_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && tc_evt == '0) |=> ($past(tc_q) == tc_q));
endmodule

// File: tb/tb_dma_status_mirror.sv
module tb_dma_status_mirror;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] mask;
        logic [3:0] req;
        logic [3:0] tc;
        logic [7:0] stat;
        logic       irq;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{8'hFF, 4'b0001, 4'b0000, 8'h10, 1'b1},
        '{8'hFF, 4'b0001, 4'b0100, 8'h14, 1'b1},
        '{8'h0F, 4'b0011, 4'b0000, 8'h30, 1'b0},
        '{8'h0F, 4'b0011, 4'b1000, 8'h38, 1'b1},
        '{8'h20, 4'b0011, 4'b0000, 8'h30, 1'b0},
        '{8'h80, 4'b1000, 4'b0000, 8'h80, 1'b1},
        '{8'h01, 4'b0000, 4'b0001, 8'h01, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [3:0] req_in = 4'h0;
    logic [3:0] tc_evt = 4'h0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] rd;

    dma_status_mirror dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_in(req_in), .tc_evt(tc_evt), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic win_read(output logic [7:0] d);
        reg_addr = 2'd3; reg_rd = 1'b1;
        #1;
        d = reg_rdata;
        step();
        reg_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        peek(2'd0, rd); chk("R10 status after reset", rd, 8'h00);
        peek(2'd1, rd); chk("R10 mask after reset", rd, 8'h00);
        chk("R10 irq after reset", {7'b0, irq}, 8'h00);

        // Vector walk: R1 R2 R6 R7
        for (int i = 0; i < NV; i++) begin
            wr_reg(2'd1, VEC[i].mask);
            win_read(rd);
            wr_reg(2'd2, 8'h01);
            req_in = VEC[i].req; tc_evt = VEC[i].tc;
            step();
            tc_evt = 4'h0;
            step();
            peek(2'd0, rd);
            chk($sformatf("R1/R2 vector %0d status", i), rd, VEC[i].stat);
            chk($sformatf("R6/R7 vector %0d irq", i), {7'b0, irq}, {7'b0, VEC[i].irq});
        end

        // R9: irq readback at address 2
        peek(2'd2, rd); chk("R9 irq readback", rd, {7'b0, irq});

        // R8: write 0 does not clear, the flag persists, write 1 clears
        wr_reg(2'd2, 8'hFE);
        step(); step();
        chk("R8 write of 0 keeps flag", {7'b0, irq}, 8'h01);
        wr_reg(2'd2, 8'h01);
        chk("R8 write of 1 clears flag", {7'b0, irq}, 8'h00);

        // R3: reading the mirror with the strobe leaves TC bits intact (tc0 set from the last vector)
        reg_addr = 2'd0; reg_rd = 1'b1;
        step(); step();
        reg_rd = 1'b0;
        peek(2'd0, rd); chk("R3 mirror read has no side effect", rd, 8'h01);

        // R5: writes to status and window addresses are ignored
        wr_reg(2'd0, 8'hFF);
        wr_reg(2'd3, 8'hFF);
        peek(2'd0, rd); chk("R5 write to status ignored", rd, 8'h01);
        peek(2'd1, rd); chk("R5 mask readback", rd, 8'h01);

        // R4: window read returns status, clears TC, keeps requests
        req_in = 4'b0110;
        step();
        win_read(rd); chk("R4 window read data", rd, 8'h61);
        peek(2'd0, rd); chk("R4 TC cleared, requests kept", rd, 8'h60);

        // R4: event in the same cycle as a window read wins
        tc_evt = 4'b0100; step(); tc_evt = 4'b0000;
        tc_evt = 4'b0001;
        win_read(rd);
        tc_evt = 4'b0000;
        peek(2'd0, rd); chk("R4 event beats window clear", rd, 8'h61);

        // R8: clear in the same cycle as an enabled rise leaves the flag set
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd2, 8'h01);
        chk("R8 flag cleared before race", {7'b0, irq}, 8'h00);
        req_in = 4'b1110;
        step();
        wr_reg(2'd2, 8'h01);
        chk("R8 rise wins over clear", {7'b0, irq}, 8'h01);
        wr_reg(2'd2, 8'h01);
        chk("R8 clear after race", {7'b0, irq}, 8'h00);

        // R6: a fall of an enabled bit does not set the flag
        req_in = 4'b0000;
        step(); step();
        chk("R6 fall does not set flag", {7'b0, irq}, 8'h00);

        // R10: reset mid-run clears mask, flag and source flags
        tc_evt = 4'b1111; step(); tc_evt = 4'b0000;
        step();
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        peek(2'd0, rd); chk("R10 status after mid-run reset", rd, 8'h00);
        peek(2'd1, rd); chk("R10 mask after mid-run reset", rd, 8'h00);
        chk("R10 irq after mid-run reset", {7'b0, irq}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule